// File: doc/BRIEF.md
# Serial Shift-Register Chain Writer

This block loads a string of N identical M-bit serial-in shift-register devices that are wired output-to-input, so that the whole string sits behind one shared active-low select and one serial clock. A request carries N words, each addressed by the position of the device it is meant for; position 0 is the device wired directly to the controller's data output. The controller pulls the select low, clocks out all N*M bits in one unbroken run, and then lets the select rise, which makes every device move its shift contents into its output register at the same instant.

Because bits travel through the string, the word meant for the farthest device has to go out first and the word for position 0 has to go out last. The controller takes care of that order. Requests arrive on a valid/ready port: `req_ready` is high only while the controller is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high. While a transfer is running, `req_ready` stays low and the requester must hold or withdraw its request; nothing is queued. A request can also be marked as a chain test. In that case the controller compares the bits coming back on `loop_in`, the serial output of the position-0 device, against what it sent one word time earlier, and reports pass or fail when the transfer finishes.

Top module: `dc_chain_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Once accepted, `req_ready` stays low until the transfer ends, and `req_valid` has no effect while it is low.
- R2: For each accepted request, `cs_n` goes low and stays low without a break while exactly N*M rising edges of `sclk` occur.
- R3: The bit order is the word for position N-1 first, then each lower position in turn, with position 0 last. Each word goes out most significant bit first, and word i is taken from `req_data[i*M +: M]`.
- R4: Serial mode 0 is used. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low, so it is stable at every rising edge and for the whole high phase of `sclk`.
- R5: `cs_n` rises only after the last falling edge of `sclk`, at least HALF clock cycles after it, and `sclk` is low when `cs_n` rises.
- R6: When a transfer completes, every device's output register holds the word addressed to it. Device outputs do not change before `cs_n` rises.
- R7: In a test transfer (`req_test`=1 at acceptance), `loop_in` is sampled at each rising `sclk` edge. The sample at edge k (counting from 0) is compared with the bit sent at edge k-M for every k ≥ M. Samples at edges 0..M-1 are ignored.
- R8: After a test transfer, `test_pass`=1 and `test_fail`=0 if every compared sample matched; otherwise `test_pass`=0 and `test_fail`=1. Both flags are cleared when a request is accepted. A normal transfer leaves both flags at 0 whatever `loop_in` does. The two flags are never both high.
- R9: `done` is a single-cycle pulse. It is issued HALF cycles after `cs_n` rises, while `cs_n` is high and `req_ready` is high.
- R10: During and after reset, `cs_n`=1, `sclk`=0, `mosi`=0, `req_ready`=1, and `done`, `test_pass` and `test_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_data | input | N*M | Word for position i at bits [i*M +: M] |
| req_test | input | 1 | Treat this request as a chain test |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data into position 0 |
| cs_n | output | 1 | Shared select; rising edge latches all devices |
| loop_in | input | 1 | Serial output of the position-0 device |
| done | output | 1 | One-cycle pulse at end of transfer |
| test_pass | output | 1 | Last test transfer matched |
| test_fail | output | 1 | Last test transfer mismatched |

## Verification
The assertions check on every cycle the properties that relate only to the pins. These are the idle-low clock while deselected, `mosi` held steady through each high phase, the exact edge count at each select rise, the clock being low when the select rises, the handshake dropping `req_ready` after acceptance, the one-cycle `done` pulse, and the two test flags never being set together. The bench scenarios cover what needs a model of the device string. They check that each device latches its own word, that outputs do not move before the select rises, that the transmitted order matches the farthest-first rule, and that a corrupted return bit changes the test verdict only when it falls in a compared position.

// File: rtl/dc_chain_pkg.sv
package dc_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } dc_state_e;
endpackage

// File: rtl/dc_tick.sv
// Half-period timer: pulses once every HALF cycles while run is high.
module dc_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dc_serializer.sv
// Holds the whole frame and presents it one bit at a time.
// Frame order: position N-1 first, position 0 last, MSB first per word.
module dc_serializer #(
  parameter int N = 4,
  parameter int M = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          shift,
  input  logic [N*M-1:0]                data,
  output logic                          bit_out,
  output logic [$clog2(N*M+1)-1:0]      bit_idx,
  output logic                          last
);
  localparam int NM = N * M;
  localparam int IW = $clog2(NM + 1);

  logic [NM-1:0] stream;
  logic [NM-1:0] sr;

  // Slot p of the frame (p = 0 goes out first) carries the word of
  // position N-1-p.
  for (genvar p = 0; p < N; p++) begin : g_slot
    assign stream[NM-1-p*M -: M] = data[(N-1-p)*M +: M];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_idx <= '0;
    end else if (load) begin
      sr      <= stream;
      bit_idx <= '0;
    end else if (shift) begin
      sr      <= sr << 1;
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assign bit_out = sr[NM-1];
  assign last    = (bit_idx == IW'(NM - 1));
endmodule

// File: rtl/dc_loopchk.sv
// Compares returned bits against the bits sent one word earlier.
module dc_loopchk #(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic sent_bit,
  input  logic ret_bit,
  output logic mismatch
);
  localparam int FW = $clog2(M + 1);

  logic [M-1:0]  dline;
  logic [FW-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dline    <= '0;
      fill     <= '0;
      mismatch <= 1'b0;
    end else if (clear) begin
      dline    <= '0;
      fill     <= '0;
      mismatch <= 1'b0;
    end else if (sample) begin
      if (fill == FW'(M)) begin
        if (ret_bit != dline[M-1]) mismatch <= 1'b1;
      end else begin
        fill <= fill + 1'b1;
      end
      dline <= (dline << 1) | M'(sent_bit);
    end
  end
endmodule

// File: rtl/dc_chain_ctrl.sv
module dc_chain_ctrl
  import dc_chain_pkg::*;
#(
  parameter int N    = 4,
  parameter int M    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [N*M-1:0] req_data,
  input  logic         req_test,
  output logic         sclk,
  output logic         mosi,
  output logic         cs_n,
  input  logic         loop_in,
  output logic         done,
  output logic         test_pass,
  output logic         test_fail
);
  localparam int NM = N * M;
  localparam int IW = $clog2(NM + 1);

  dc_state_e state;
  logic      sclk_q, cs_q, done_q, pass_q, fail_q, test_q;
  logic      tick, accept, rise_ev, fall_ev;
  logic      ser_bit, ser_last, mis;
  logic [IW-1:0] ser_idx;

  assign accept  = req_valid && (state == ST_IDLE);
  assign rise_ev = (state == ST_SHIFT) && tick && !sclk_q;
  assign fall_ev = (state == ST_SHIFT) && tick && sclk_q;

  dc_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state != ST_IDLE),
    .tick (tick)
  );

  dc_serializer #(.N(N), .M(M)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .shift  (fall_ev && !ser_last),
    .data   (req_data),
    .bit_out(ser_bit),
    .bit_idx(ser_idx),
    .last   (ser_last)
  );

  dc_loopchk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .sample  (rise_ev && test_q),
    .sent_bit(ser_bit),
    .ret_bit (loop_in),
    .mismatch(mis)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_q   <= 1'b0;
            test_q <= req_test;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
          end else if (fall_ev) begin
            sclk_q <= 1'b0;
            if (ser_last) state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_q  <= 1'b1;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            done_q <= 1'b1;
            pass_q <= test_q && !mis;
            fail_q <= test_q && mis;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = ser_bit & ~cs_q;
  assign done      = done_q;
  assign test_pass = pass_q;
  assign test_fail = fail_q;
endmodule

// File: rtl/dc_chain_chk.sv
module dc_chain_chk #(
  parameter int N = 4,
  parameter int M = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic done,
  input logic test_pass,
  input logic test_fail
);
  localparam int NM = N * M;

  logic        sclk_d;
  logic [15:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  AST_HANDSHAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rises == 16'(NM))); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R4
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && sclk_d) |-> $stable(mosi)); // R4
  AST_CS_RISE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !sclk_d)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_pass && test_fail)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && req_ready)); // R9
endmodule

bind dc_chain_ctrl dc_chain_chk #(.N(N), .M(M)) u_dc_chain_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .sclk     (sclk),
  .mosi     (mosi),
  .cs_n     (cs_n),
  .done     (done),
  .test_pass(test_pass),
  .test_fail(test_fail)
);

// File: tb/tb_dc_chain_ctrl.sv
module tb_dc_chain_ctrl;
  localparam int N    = 4;
  localparam int M    = 8;
  localparam int HALF = 2;
  localparam int NM   = N * M;
  localparam int NV   = 6;
  localparam int NONE = 255;

  // vector table: data, test flag, injected error edge (NONE = clean)
  localparam logic [NM-1:0] VDATA [NV] = '{32'hA5C3_0F96, 32'h0123_4567,
      32'hFFFF_0000, 32'hDEAD_BEEF, 32'h8000_0001, 32'h0000_0000};
  localparam logic VTEST [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int   VINJ  [NV] = '{NONE, NONE, 8, 3, 31, 10};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_test = 1'b0;
  logic [NM-1:0] req_data = '0;
  logic req_ready, sclk, mosi, cs_n, loop_in, done, test_pass, test_fail;

  int checks = 0, fails = 0;
  int edge_cnt = 0, mosi_viol = 0, csrise_bad = 0, inj_pos = NONE;
  logic [NM-1:0] cap = '0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
  logic [M-1:0] sh [N];
  logic [M-1:0] lat [N];

  always #2 clk = ~clk; // 250 MHz

  dc_chain_ctrl #(.N(N), .M(M), .HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_test(req_test), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .loop_in(loop_in), .done(done), .test_pass(test_pass),
    .test_fail(test_fail));

  // model of the device string
  initial begin
    for (int i = 0; i < N; i++) begin sh[i] = '0; lat[i] = '0; end
  end
  always @(posedge sclk) if (!cs_n) begin
    sh[0] <= {sh[0][M-2:0], mosi};
    for (int i = 1; i < N; i++) sh[i] <= {sh[i][M-2:0], sh[i-1][M-1]};
  end
  always @(posedge cs_n) for (int i = 0; i < N; i++) lat[i] <= sh[i];
  assign loop_in = sh[0][M-1] ^ (edge_cnt == inj_pos);

  // pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!cs_n && prev_cs) edge_cnt = 0;
    if (sclk && !prev_sclk && !cs_n) begin
      cap = {cap[NM-2:0], mosi};
      edge_cnt = edge_cnt + 1;
    end
    if (sclk && prev_sclk && (mosi != prev_mosi)) mosi_viol++;
    if (cs_n && !prev_cs && (sclk || prev_sclk)) csrise_bad++;
    prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 2000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_txn(input logic [NM-1:0] d, input logic t, input int inj,
                         input bit junk_while_busy);
    bit seen;
    logic [NM-1:0] old;
    logic ep, ef;
    for (int i = 0; i < N; i++) old[i*M +: M] = lat[i];
    @(negedge clk);
    req_valid = 1'b1; req_data = d; req_test = t; inj_pos = inj;
    @(negedge clk);
    check(!req_ready && !cs_n, "R1", {req_ready, cs_n}, 2'b00);
    if (junk_while_busy) begin
      req_data = ~d; req_test = ~t;
      repeat (20) @(negedge clk);
    end
    req_valid = 1'b0;
    while (edge_cnt < NM - 1) @(negedge clk);
    begin
      logic [NM-1:0] mid;
      for (int i = 0; i < N; i++) mid[i*M +: M] = lat[i];
      check(mid == old, "R6 outputs before latch", mid, old);
    end
    wait_done(seen);
    check(seen, "R9 done seen", seen, 1);
    check(edge_cnt == NM, "R2 edge count", edge_cnt, NM);
    check(cap == d, "R3 transmit order", cap, d);
    for (int i = 0; i < N; i++)
      check(lat[i] == d[i*M +: M], "R6 device word", lat[i], d[i*M +: M]);
    ep = t && !(inj >= M && inj < NM);
    ef = t && (inj >= M && inj < NM);
    check(test_pass == ep && test_fail == ef, "R7 R8 verdict",
          {test_pass, test_fail}, {ep, ef});
    check(req_ready && cs_n, "R1 idle after done", {req_ready, cs_n}, 2'b11);
    @(negedge clk);
    check(!done, "R9 single pulse", done, 0);
    inj_pos = NONE;
  endtask

  initial begin
    begin : watchdog
      #400000;
      fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !mosi && req_ready && !done && !test_pass && !test_fail,
          "R10 reset values", {cs_n, sclk, mosi, req_ready, done, test_pass, test_fail},
          7'b1001000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !sclk && req_ready, "R10 after reset", {cs_n, sclk, req_ready}, 3'b101);

    // table walk
    for (int v = 0; v < NV; v++) run_txn(VDATA[v], VTEST[v], VINJ[v], 1'b0);

    // R1: request driven while busy is ignored; devices keep first word set
    run_txn(32'h1357_9BDF, 1'b1, NONE, 1'b1);
    // R8: flags from a test are cleared by a following normal request
    run_txn(32'h55AA_33CC, 1'b0, 12, 1'b0);
    check(!test_pass && !test_fail, "R8 normal clears flags", {test_pass, test_fail}, 0);
    // R7: error in the last ignored position does not change the verdict
    run_txn(32'hF0F0_0F0F, 1'b1, M - 1, 1'b0);

    check(mosi_viol == 0, "R4 mosi stable in high phase", mosi_viol, 0);
    check(csrise_bad == 0, "R5 clock low at select rise", csrise_bad, 0);
    check(!sclk && cs_n, "R4 idle clock low", {sclk, cs_n}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule